// File: doc/BRIEF.md
# Two-Word Instruction Stream Decoder

This block takes a stream of 16-bit instruction words, at most one per cycle and qualified by a valid input. For each complete instruction it produces one decoded result: an operation class and the register indices and constant packed into that instruction. In the encoding the operand fields are spread over bits that are not next to each other. The decoder puts them back together into plain indices and values.

Absolute jump and absolute call take two words. The first word carries the upper six bits of a 22-bit target and selects jump or call. The block keeps those bits while it waits for the next valid word, which supplies the low sixteen target bits. It then reports the instruction as one result. Words that match no known pattern are reported with an illegal flag. Execution, operand reads and memory access belong to other blocks.

All outputs are registered. A result appears in the cycle after the word that completes the instruction is accepted. The reset is synchronous.

Top module: `instrStreamDecoder`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `outValid`=0 and `outIllegal`=0, and any pending first word is dropped.
- R2: A word accepted with `inValid`=1 that completes an instruction gives `outValid`=1 for exactly the following cycle. A cycle with `inValid`=0 gives `outValid`=0 in the following cycle. Single-word results show `outTarget`=0.
- R3: Two-register forms use bits 15:10: 000011=ADD(7), 000110=SUB(8), 001000=AND(9), 001001=EOR(10), 001010=OR(11), 001011=MOV(12), 100111=MUL(13). The destination is bits 8:4. The source is {bit 9, bits 3:0}. The immediate is 0.
- R4: Constant forms use bits 15:12: 0011=CPI(14), 0100=SBCI(15), 0101=SUBI(16), 0110=ORI(17), 0111=ANDI(18), 1110=LDI(19). The destination is 16+bits 7:4. The 8-bit constant is {bits 11:8, bits 3:0}. The source is 0.
- R5: Bits 15:8=00000010 gives MULS(2), with destination 16+bits 7:4 and source 16+bits 3:0. Bits 15:8=00000011 gives a narrow multiply selected by {bit 7, bit 3}: 00=MULSU(3), 01=FMUL(4), 10=FMULS(5), 11=FMULSU(6). Its destination is 16+bits 6:4 and its source is 16+bits 2:0.
- R6: Bits 15:8=00000001 gives MOVW(1), with destination 2·bits 7:4 and source 2·bits 3:0.
- R7: Bits 15:9=1001011 gives ADIW(20) when bit 8 is 0 and SBIW(21) when bit 8 is 1. The destination is 24+2·bits 5:4. The 6-bit constant is {bits 7:6, bits 3:0}. The source is 0.
- R8: A word with bits 15:9=1001010 and bits 3:2=11 is the first word of JMP(22) (bit 1=0) or CALL(23) (bit 1=1). Accepting it gives no result. The next accepted word completes the instruction, and the result shows `outTarget`={bits 8:4, bit 0 of the first word, the second word}.
- R9: While a first word is pending, cycles with `inValid`=0 keep it pending. The next accepted word is used only as target bits and is never classified, so `outIllegal`=0 whatever its value.
- R10: The all-zero word decodes as NOP(0), with all fields 0.
- R11: Any other word gives `outValid`=1 with `outIllegal`=1, `outOp`=ILLEGAL(31), and `outDst`, `outSrc`, `outImm` and `outTarget` all 0. `outIllegal` is never high without `outValid`.
- R12: A reset while a first word is pending cancels it. The next accepted word is decoded as a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | `inWord` is offered this cycle |
| inWord | input | 16 | Instruction or target word |
| outValid | output | 1 | One-cycle strobe per decoded instruction |
| outOp | output | 5 | Operation class code |
| outDst | output | 5 | Destination register index |
| outSrc | output | 5 | Source register index |
| outImm | output | 8 | Rebuilt constant |
| outTarget | output | 22 | Absolute target for jump and call |
| outIllegal | output | 1 | Word matched no pattern |

## Verification
The only hidden state is the pending flag and the six saved target bits. If the flag is wrong, the effect shows in the cycle after the next accepted word. That result is then missing, or a stray JMP or CALL appears, or a target word is reported as its own instruction. The vector table moves through every operation class back to back, so a wrong field position shows as a bad index or constant on the very next cycle. Directed cases place idle gaps between the two words of a jump, use target words that would otherwise decode as illegal or NOP, and reset in the middle of a jump.

// File: rtl/instrDecPkg.sv
package instrDecPkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 8;
  localparam int TGT_W  = 22;
  localparam int OP_W   = 5;
  localparam int HI_W   = TGT_W - WORD_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 5'd0,
    OP_MOVW   = 5'd1,
    OP_MULS   = 5'd2,
    OP_MULSU  = 5'd3,
    OP_FMUL   = 5'd4,
    OP_FMULS  = 5'd5,
    OP_FMULSU = 5'd6,
    OP_ADD    = 5'd7,
    OP_SUB    = 5'd8,
    OP_AND    = 5'd9,
    OP_EOR    = 5'd10,
    OP_OR     = 5'd11,
    OP_MOV    = 5'd12,
    OP_MUL    = 5'd13,
    OP_CPI    = 5'd14,
    OP_SBCI   = 5'd15,
    OP_SUBI   = 5'd16,
    OP_ORI    = 5'd17,
    OP_ANDI   = 5'd18,
    OP_LDI    = 5'd19,
    OP_ADIW   = 5'd20,
    OP_SBIW   = 5'd21,
    OP_JMP    = 5'd22,
    OP_CALL   = 5'd23,
    OP_ILLEGAL = 5'd31
  } opClass_e;

  typedef struct packed {
    logic captureFirst;
    logic emitSingle;
    logic emitLong;
  } ctlStrobes_t;

  typedef struct packed {
    opClass_e           op;
    logic [REG_W-1:0]   dst;
    logic [REG_W-1:0]   src;
    logic [IMM_W-1:0]   imm;
    logic               illegal;
    logic               twoWord;
  } decoded_t;
endpackage

// File: rtl/decClassify.sv
module decClassify
  import instrDecPkg::*;
(
  input  logic [WORD_W-1:0] word,
  output decoded_t          dec
);
  always_comb begin
    dec = '0;
    dec.op = OP_ILLEGAL;
    dec.illegal = 1'b1;
    casez (word)
      16'b0000_0000_0000_0000: begin
        dec.op = OP_NOP;
        dec.illegal = 1'b0;
      end
      16'b0000_0001_????_????: begin
        dec.op = OP_MOVW;
        dec.illegal = 1'b0;
        dec.dst = {word[7:4], 1'b0};
        dec.src = {word[3:0], 1'b0};
      end
      16'b0000_0010_????_????: begin
        dec.op = OP_MULS;
        dec.illegal = 1'b0;
        dec.dst = {1'b1, word[7:4]};
        dec.src = {1'b1, word[3:0]};
      end
      16'b0000_0011_????_????: begin
        dec.illegal = 1'b0;
        dec.dst = {2'b10, word[6:4]};
        dec.src = {2'b10, word[2:0]};
        case ({word[7], word[3]})
          2'b00:   dec.op = OP_MULSU;
          2'b01:   dec.op = OP_FMUL;
          2'b10:   dec.op = OP_FMULS;
          default: dec.op = OP_FMULSU;
        endcase
      end
      16'b0000_11??_????_????, 16'b0001_10??_????_????,
      16'b0010_????_????_????, 16'b1001_11??_????_????: begin
        dec.illegal = 1'b0;
        dec.dst = word[8:4];
        dec.src = {word[9], word[3:0]};
        case (word[15:10])
          6'b000011: dec.op = OP_ADD;
          6'b000110: dec.op = OP_SUB;
          6'b001000: dec.op = OP_AND;
          6'b001001: dec.op = OP_EOR;
          6'b001010: dec.op = OP_OR;
          6'b001011: dec.op = OP_MOV;
          default:   dec.op = OP_MUL;
        endcase
      end
      16'b0011_????_????_????, 16'b01??_????_????_????,
      16'b1110_????_????_????: begin
        dec.illegal = 1'b0;
        dec.dst = {1'b1, word[7:4]};
        dec.imm = {word[11:8], word[3:0]};
        case (word[15:12])
          4'b0011: dec.op = OP_CPI;
          4'b0100: dec.op = OP_SBCI;
          4'b0101: dec.op = OP_SUBI;
          4'b0110: dec.op = OP_ORI;
          4'b0111: dec.op = OP_ANDI;
          default: dec.op = OP_LDI;
        endcase
      end
      16'b1001_011?_????_????: begin
        dec.illegal = 1'b0;
        dec.op = word[8] ? OP_SBIW : OP_ADIW;
        dec.dst = {2'b11, word[5:4], 1'b0};
        dec.imm = {2'b00, word[7:6], word[3:0]};
      end
      16'b1001_010?_????_11??: begin
        dec.illegal = 1'b0;
        dec.twoWord = 1'b1;
        dec.op = word[1] ? OP_CALL : OP_JMP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/decControl.sv
module decControl
  import instrDecPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        isTwoWord,
  output ctlStrobes_t strobes,
  output logic        pendingQ
);
  always_comb begin
    strobes.captureFirst = inValid && !pendingQ && isTwoWord;
    strobes.emitSingle   = inValid && !pendingQ && !isTwoWord;
    strobes.emitLong     = inValid && pendingQ;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pendingQ <= 1'b0;
    else if (strobes.captureFirst)
      pendingQ <= 1'b1;
    else if (strobes.emitLong)
      pendingQ <= 1'b0;
  end
endmodule

// File: rtl/decDatapath.sv
module decDatapath
  import instrDecPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] inWord,
  input  ctlStrobes_t       strobes,
  input  decoded_t          dec,
  output logic              outValid,
  output opClass_e          outOp,
  output logic [REG_W-1:0]  outDst,
  output logic [REG_W-1:0]  outSrc,
  output logic [IMM_W-1:0]  outImm,
  output logic [TGT_W-1:0]  outTarget,
  output logic              outIllegal
);
  logic [HI_W-1:0] pendHi;
  logic            pendCall;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendHi   <= '0;
      pendCall <= 1'b0;
    end else if (strobes.captureFirst) begin
      pendHi   <= {inWord[8:4], inWord[0]};
      pendCall <= inWord[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outOp      <= OP_NOP;
      outDst     <= '0;
      outSrc     <= '0;
      outImm     <= '0;
      outTarget  <= '0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= strobes.emitSingle || strobes.emitLong;
      outIllegal <= strobes.emitSingle && dec.illegal;
      if (strobes.emitLong) begin
        outOp     <= pendCall ? OP_CALL : OP_JMP;
        outDst    <= '0;
        outSrc    <= '0;
        outImm    <= '0;
        outTarget <= {pendHi, inWord};
      end else if (strobes.emitSingle) begin
        outOp     <= dec.op;
        outDst    <= dec.dst;
        outSrc    <= dec.src;
        outImm    <= dec.imm;
        outTarget <= '0;
      end
    end
  end
endmodule

// File: rtl/instrStreamDecoder.sv
module instrStreamDecoder
  import instrDecPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [15:0] inWord,
  output logic        outValid,
  output logic [4:0]  outOp,
  output logic [4:0]  outDst,
  output logic [4:0]  outSrc,
  output logic [7:0]  outImm,
  output logic [21:0] outTarget,
  output logic        outIllegal
);
  decoded_t    dec;
  ctlStrobes_t strobes;
  logic        pendingQ;
  opClass_e    opQ;

  decClassify uClassify (
    .word (inWord),
    .dec  (dec)
  );

  decControl uControl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .isTwoWord (dec.twoWord),
    .strobes   (strobes),
    .pendingQ  (pendingQ)
  );

  decDatapath uDatapath (
    .clk        (clk),
    .rst        (rst),
    .inWord     (inWord),
    .strobes    (strobes),
    .dec        (dec),
    .outValid   (outValid),
    .outOp      (opQ),
    .outDst     (outDst),
    .outSrc     (outSrc),
    .outImm     (outImm),
    .outTarget  (outTarget),
    .outIllegal (outIllegal)
  );

  assign outOp = opQ;
endmodule

// File: rtl/instrStreamDecoder_chk.sv
module instrStreamDecoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [15:0] inWord,
  input logic        pendingQ,
  input logic        outValid,
  input logic [4:0]  outOp,
  input logic [4:0]  outDst,
  input logic [21:0] outTarget,
  input logic        outIllegal
);
  // R1: the cycle after a reset edge carries no result
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && !outIllegal && !pendingQ));

  // R2: an idle cycle yields no result
  assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R8: a first jump/call word is absorbed and leaves a word pending
  assert_first_word_held_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && !pendingQ && inWord[15:9] == 7'b1001010 && inWord[3:2] == 2'b11)
      |=> (!outValid && pendingQ));

  // R9: a word taken while pending becomes the low target half, never illegal
  assert_second_word_merged_R9: assert property (@(posedge clk) disable iff (rst)
    (inValid && pendingQ) |=>
      (outValid && !outIllegal && !pendingQ && outTarget[15:0] == $past(inWord)
       && (outOp == 5'd22 || outOp == 5'd23)));

  // R9: idle cycles keep a pending word
  assert_pending_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (pendingQ && !inValid) |=> pendingQ);

  // R11: illegal flag only with a result and with the illegal code
  assert_illegal_framed_R11: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> (outValid && outOp == 5'd31 && outTarget == 22'd0));

  // R4: constant forms only reach the upper sixteen registers
  assert_const_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (outValid && outOp >= 5'd14 && outOp <= 5'd19) |-> outDst[4]);
endmodule

bind instrStreamDecoder instrStreamDecoder_chk uChk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inWord     (inWord),
  .pendingQ   (pendingQ),
  .outValid   (outValid),
  .outOp      (outOp),
  .outDst     (outDst),
  .outTarget  (outTarget),
  .outIllegal (outIllegal)
);

// File: tb/instrStreamDecoder_test.sv
`timescale 1ns/1ps
module instrStreamDecoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inWord = '0;
  logic        outValid;
  logic [4:0]  outOp;
  logic [4:0]  outDst;
  logic [4:0]  outSrc;
  logic [7:0]  outImm;
  logic [21:0] outTarget;
  logic        outIllegal;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  instrStreamDecoder uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outOp(outOp), .outDst(outDst), .outSrc(outSrc),
    .outImm(outImm), .outTarget(outTarget), .outIllegal(outIllegal)
  );

  // {word, op, dst, src, imm}, one byte per field after the word
  localparam int NVEC = 25;
  localparam logic [47:0] VEC [NVEC] = '{
    48'h0000_00_00_00_00, 48'h0F4F_07_14_1F_00, 48'h1A30_08_03_10_00,
    48'h2001_09_00_01_00, 48'h25F0_0A_1F_00_00, 48'h2856_0B_05_06_00,
    48'h2F01_0C_10_11_00, 48'h9C23_0D_02_03_00, 48'hEA75_13_17_00_A5,
    48'h330C_0E_10_00_3C, 48'h4FFF_0F_1F_00_FF, 48'h5021_10_12_00_01,
    48'h6890_11_19_00_80, 48'h704F_12_14_00_0F, 48'h01E3_01_1C_06_00,
    48'h02A5_02_1A_15_00, 48'h0352_03_15_12_00, 48'h030F_04_10_17_00,
    48'h03B1_05_13_11_00, 48'h03FF_06_17_17_00, 48'h96FF_14_1E_00_3F,
    48'h9742_15_18_00_12, 48'h0001_1F_00_00_00, 48'hFFFF_1F_00_00_00,
    48'h9508_1F_00_00_00
  };

  function automatic string reqOf(input logic [4:0] op);
    if (op == 5'd0) return "R10";
    if (op == 5'd1) return "R6";
    if (op <= 5'd6) return "R5";
    if (op <= 5'd13) return "R3";
    if (op <= 5'd19) return "R4";
    if (op <= 5'd21) return "R7";
    return "R11";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // drive one cycle, then sample just after the capturing edge
  task automatic step(input logic v, input logic [15:0] w);
    @(negedge clk);
    inValid = v;
    inWord  = w;
    @(posedge clk);
    #1;
  endtask

  task automatic expectResult(input string req, input logic [4:0] op,
                              input logic [4:0] d, input logic [4:0] s,
                              input logic [7:0] k, input logic [21:0] tgt,
                              input logic ill);
    check(req, "valid", 32'(outValid), 32'd1);
    check(req, "op", 32'(outOp), 32'(op));
    check(req, "dst", 32'(outDst), 32'(d));
    check(req, "src", 32'(outSrc), 32'(s));
    check(req, "imm", 32'(outImm), 32'(k));
    check(req, "target", 32'(outTarget), 32'(tgt));
    check(req, "illegal", 32'(outIllegal), 32'(ill));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1'b0, 16'h0);
    step(1'b0, 16'h0);
    check("R1", "valid after reset", 32'(outValid), 32'd0);
    check("R1", "illegal after reset", 32'(outIllegal), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // table walk, back to back
    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] v;
      v = VEC[i];
      step(1'b1, v[47:32]);
      expectResult(reqOf(v[28:24]), v[28:24], v[20:16], v[12:8], v[7:0],
                   22'd0, (v[28:24] == 5'd31));
    end

    // R2: idle cycle gives no result
    step(1'b0, 16'h0F4F);
    check("R2", "idle valid", 32'(outValid), 32'd0);

    // R8/R9: jump with an idle gap and an otherwise illegal second word
    step(1'b1, 16'h95DC);
    check("R8", "first word no result", 32'(outValid), 32'd0);
    step(1'b0, 16'h0000);
    check("R9", "gap no result", 32'(outValid), 32'd0);
    step(1'b0, 16'h0F4F);
    check("R9", "gap2 no result", 32'(outValid), 32'd0);
    step(1'b1, 16'hFFFF);
    expectResult("R8", 5'd22, 5'd0, 5'd0, 8'd0, 22'h3AFFFF, 1'b0);

    // R2: a single-word instruction right after clears the target
    step(1'b1, 16'h0F4F);
    expectResult("R2", 5'd7, 5'd20, 5'd31, 8'd0, 22'd0, 1'b0);

    // R8/R9: call whose second word is all zero, not a NOP
    step(1'b1, 16'h95DF);
    check("R8", "call first no result", 32'(outValid), 32'd0);
    step(1'b1, 16'h0000);
    expectResult("R9", 5'd23, 5'd0, 5'd0, 8'd0, 22'h3B0000, 1'b0);

    // R8: jump target with mixed bits, back to back with next jump
    step(1'b1, 16'h95DC);
    step(1'b1, 16'hBCDE);
    expectResult("R8", 5'd22, 5'd0, 5'd0, 8'd0, 22'h3ABCDE, 1'b0);
    step(1'b1, 16'h940F);
    check("R8", "second jump first no result", 32'(outValid), 32'd0);
    step(1'b1, 16'h1234);
    expectResult("R8", 5'd23, 5'd0, 5'd0, 8'd0, 22'h011234, 1'b0);

    // R12: reset while pending, next word decodes on its own
    step(1'b1, 16'h95DC);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(posedge clk);
    #1;
    check("R1", "valid during reset", 32'(outValid), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 16'h0F4F);
    expectResult("R12", 5'd7, 5'd20, 5'd31, 8'd0, 22'd0, 1'b0);
    step(1'b0, 16'h0);
    check("R12", "no stray result", 32'(outValid), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule